// File: doc/BRIEF.md
# SD host interrupt status and mask controller

This block keeps the interrupt bookkeeping of an SD host controller. A raw status word collects single-cycle set pulses from the command and data engines, plus the card insertion and removal events. A mask word selects which raw bits may reach the single interrupt line. An interrupt-enable bit in a global control word gates that line. Software clears raw bits by writing ones. The write can go to either of two addresses: the raw view or the masked view. The two views differ only on read.

A card-present flag lives in a separate status word. Card events drive it, and software can knock it down by writing a one. The card-insert and card-remove raw flags never stand together. When a card event or a set pulse meets a software clear on the same bit in the same cycle, the hardware event is kept. The interrupt output is a flop. It reflects the register contents starting one clock after the write or pulse that changed them.

Register word addresses (`wrAddr` / `rdAddr`):

| Address | Register |
|---------|----------|
| 0 | Global control |
| 1 | Mask |
| 2 | Masked status view |
| 3 | Raw status view |
| 4 | Card status |

Addresses 5 to 7 are unmapped.

Top module: `sd_irq_status_ctl`

## Requirements
- R1: After reset, the registers hold these values: global control reads 0x300, mask reads 0, raw status reads 0, masked status reads 0, card status reads 0x100. `irqOut` is 0.
- R2: A write to address 0 (global control) stores the written word, except that bits 0, 1 and 2 always read back as 0.
- R3: `irqOut` is 1 exactly when global-control bit 4 is 1 and at least one bit of (raw AND mask) is 1. It takes the value implied by the register contents after a clock edge, from that edge on, so it follows a write or pulse by one cycle.
- R4: A read of address 2 returns raw AND mask. A read of address 3 returns the raw status.
- R5: A write to address 2 or to address 3 clears every raw bit written as 1 and leaves the other raw bits unchanged.
- R6: A 1 on bit n of `setPulse` sets raw bit n, for n from 0 to 29. Bits 30 and 31 of `setPulse` have no effect.
- R7: A `cardInsert` pulse without `cardRemove` sets raw bit 30, clears raw bit 31 and sets card-status bit 8. A `cardRemove` pulse sets raw bit 31, clears raw bit 30 and clears card-status bit 8. If both pulses arrive in the same cycle, only the removal acts.
- R8: A write to address 4 clears card-status bit 8 when the written bit 8 is 1. All other card-status bits always read 0.
- R9: When a set pulse or a card event and a write-one-to-clear target the same raw bit or status bit in the same cycle, the bit ends up set as the event dictates.
- R10: Reads of addresses 5, 6 and 7 return 0, and writes to them change no register.
- R11: A write to address 1 stores the whole word into the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write word address |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | ADDR_W | Register read word address |
| rdData | output | DATA_W | Combinational read data for rdAddr |
| setPulse | input | DATA_W | Per-bit raw status set pulses from the engines |
| cardInsert | input | 1 | Card insertion event pulse |
| cardRemove | input | 1 | Card removal event pulse |
| irqOut | output | 1 | Level interrupt line |

## Verification
A corrupted raw or mask bit shows up at once on the raw or masked read view. If that bit is both masked in and enabled, it also shows up on `irqOut` at the next clock edge. A lost self-clear of the reset bits in global control shows on the first read of address 0. A wrong priority between events and clears stays hidden until a cycle where both hit the same bit; it then shows as a stale 0 in the raw view the cycle after. The reference model compares the addressed read value and the interrupt line on every clock, so any divergence is reported within one cycle of the read that exposes it.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;

  localparam int IRQ_EN_BIT    = 4;
  localparam int SELF_CLR_BITS = 3;
  localparam int CARD_IN_BIT   = 30;
  localparam int CARD_OUT_BIT  = 31;
  localparam int PRESENT_BIT   = 8;
  localparam logic [31:0] CTRL_RESET = 32'h0000_0300;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_MASK   = 3'd1,
    SEL_MASKED = 3'd2,
    SEL_RAW    = 3'd3,
    SEL_STATE  = 3'd4,
    SEL_NONE   = 3'd7
  } regSel_t;

  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic clrRaw;
    logic clrState;
    logic cardSet;
    logic cardClr;
  } strobe_t;

endpackage

// File: rtl/sd_irq_ctl.sv
module sd_irq_ctl
  import sd_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] setPulse,
  input  logic              cardInsert,
  input  logic              cardRemove,
  output strobe_t           strb,
  output logic [DATA_W-1:0] eventSet,
  output regSel_t           rdSel
);

  localparam logic [DATA_W-1:0] CARD_MASK =
    (DATA_W'(1) << CARD_IN_BIT) | (DATA_W'(1) << CARD_OUT_BIT);

  // Card-bit positions are owned by the card events, not by the engines.
  assign eventSet = setPulse & ~CARD_MASK;

  function automatic regSel_t decodeAddr(input logic [ADDR_W-1:0] a);
    regSel_t s;
    if (a == ADDR_W'(SEL_CTRL))        s = SEL_CTRL;
    else if (a == ADDR_W'(SEL_MASK))   s = SEL_MASK;
    else if (a == ADDR_W'(SEL_MASKED)) s = SEL_MASKED;
    else if (a == ADDR_W'(SEL_RAW))    s = SEL_RAW;
    else if (a == ADDR_W'(SEL_STATE))  s = SEL_STATE;
    else                               s = SEL_NONE;
    return s;
  endfunction

  regSel_t wrSel;

  always_comb begin
    wrSel = decodeAddr(wrAddr);
    rdSel = decodeAddr(rdAddr);
  end

  always_comb begin
    strb = '0;
    // A removal overrides a simultaneous insertion.
    strb.cardClr = cardRemove;
    strb.cardSet = cardInsert & ~cardRemove;
    if (wrEn) begin
      unique case (wrSel)
        SEL_CTRL:             strb.wrCtrl   = 1'b1;
        SEL_MASK:             strb.wrMask   = 1'b1;
        SEL_MASKED, SEL_RAW:  strb.clrRaw   = 1'b1;
        SEL_STATE:            strb.clrState = 1'b1;
        default:              ;
      endcase
    end
  end

endmodule

// File: rtl/sd_irq_dp.sv
module sd_irq_dp
  import sd_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] eventSet,
  input  logic [DATA_W-1:0] wrData,
  input  regSel_t           rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic [DATA_W-1:0] ctrlVal,
  output logic [DATA_W-1:0] maskVal,
  output logic [DATA_W-1:0] rawVal,
  output logic [DATA_W-1:0] statusVal
);

  localparam logic [DATA_W-1:0] SELF_CLR_MASK = DATA_W'((1 << SELF_CLR_BITS) - 1);

  logic [DATA_W-1:0] ctrlQ, ctrlNext;
  logic [DATA_W-1:0] maskQ, maskNext;
  logic [DATA_W-1:0] rawQ, rawNext;
  logic [DATA_W-1:0] clrVec;
  logic              presentQ, presentNext;
  logic              irqQ, irqNext;

  assign ctrlNext = strb.wrCtrl ? (wrData & ~SELF_CLR_MASK) : ctrlQ;
  assign maskNext = strb.wrMask ? wrData : maskQ;
  assign clrVec   = strb.clrRaw ? wrData : '0;

  // Per-bit raw update: clear first, then the set source takes priority.
  for (genvar b = 0; b < DATA_W; b++) begin : g_raw
    if (b == CARD_IN_BIT) begin : g_in
      assign rawNext[b] = strb.cardSet | (rawQ[b] & ~clrVec[b] & ~strb.cardClr);
    end else if (b == CARD_OUT_BIT) begin : g_out
      assign rawNext[b] = strb.cardClr | (rawQ[b] & ~clrVec[b] & ~strb.cardSet);
    end else begin : g_evt
      assign rawNext[b] = eventSet[b] | (rawQ[b] & ~clrVec[b]);
    end
  end

  always_comb begin
    presentNext = presentQ;
    if (strb.clrState && wrData[PRESENT_BIT]) presentNext = 1'b0;
    if (strb.cardSet)                          presentNext = 1'b1;
    if (strb.cardClr)                          presentNext = 1'b0;
  end

  assign irqNext = ctrlNext[IRQ_EN_BIT] & (|(rawNext & maskNext));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= DATA_W'(CTRL_RESET);
      maskQ    <= '0;
      rawQ     <= '0;
      presentQ <= 1'b1;
      irqQ     <= 1'b0;
    end else begin
      ctrlQ    <= ctrlNext;
      maskQ    <= maskNext;
      rawQ     <= rawNext;
      presentQ <= presentNext;
      irqQ     <= irqNext;
    end
  end

  assign ctrlVal   = ctrlQ;
  assign maskVal   = maskQ;
  assign rawVal    = rawQ;
  assign statusVal = DATA_W'(presentQ) << PRESENT_BIT;
  assign irqOut    = irqQ;

  always_comb begin
    unique case (rdSel)
      SEL_CTRL:   rdData = ctrlQ;
      SEL_MASK:   rdData = maskQ;
      SEL_MASKED: rdData = rawQ & maskQ;
      SEL_RAW:    rdData = rawQ;
      SEL_STATE:  rdData = statusVal;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/sd_irq_status_ctl.sv
module sd_irq_status_ctl
  import sd_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] setPulse,
  input  logic              cardInsert,
  input  logic              cardRemove,
  output logic              irqOut
);

  strobe_t           strb;
  regSel_t           rdSel;
  logic [DATA_W-1:0] eventSet;
  logic [DATA_W-1:0] ctrlVal, maskVal, rawVal, statusVal;

  sd_irq_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .setPulse   (setPulse),
    .cardInsert (cardInsert),
    .cardRemove (cardRemove),
    .strb       (strb),
    .eventSet   (eventSet),
    .rdSel      (rdSel)
  );

  sd_irq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .eventSet  (eventSet),
    .wrData    (wrData),
    .rdSel     (rdSel),
    .rdData    (rdData),
    .irqOut    (irqOut),
    .ctrlVal   (ctrlVal),
    .maskVal   (maskVal),
    .rawVal    (rawVal),
    .statusVal (statusVal)
  );

endmodule

// File: rtl/sd_irq_status_ctl_chk.sv
module sd_irq_status_ctl_chk
  import sd_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] setPulse,
  input logic              cardInsert,
  input logic              cardRemove,
  input logic              irqOut,
  input logic [DATA_W-1:0] ctrlVal,
  input logic [DATA_W-1:0] maskVal,
  input logic [DATA_W-1:0] rawVal,
  input logic [DATA_W-1:0] statusVal
);

  logic noEvents;
  assign noEvents = (setPulse == '0) && !cardInsert && !cardRemove;

  assert_irq_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (ctrlVal[IRQ_EN_BIT] && (|(rawVal & maskVal))));

  assert_self_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlVal[SELF_CLR_BITS-1:0] == '0);

  assert_card_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(rawVal[CARD_IN_BIT] && rawVal[CARD_OUT_BIT]));

  assert_insert_effect_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cardInsert && !cardRemove) |=> (rawVal[CARD_IN_BIT] && statusVal[PRESENT_BIT]));

  assert_remove_effect_R7: assert property (@(posedge clk) disable iff (!rstN)
    cardRemove |=> (rawVal[CARD_OUT_BIT] && !statusVal[PRESENT_BIT]));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|setPulse[29:0]) |=> ((rawVal[29:0] & $past(setPulse[29:0])) == $past(setPulse[29:0])));

  assert_write_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && noEvents && (wrAddr == ADDR_W'(2) || wrAddr == ADDR_W'(3)))
      |=> ((rawVal & $past(wrData)) == '0));

  assert_status_bits_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusVal & ~(DATA_W'(1) << PRESENT_BIT)) == '0);

  assert_mask_store_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(1)) |=> (maskVal == $past(wrData)));

endmodule

bind sd_irq_status_ctl sd_irq_status_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .setPulse   (setPulse),
  .cardInsert (cardInsert),
  .cardRemove (cardRemove),
  .irqOut     (irqOut),
  .ctrlVal    (ctrlVal),
  .maskVal    (maskVal),
  .rawVal     (rawVal),
  .statusVal  (statusVal)
);

// File: tb/sd_irq_status_ctl_bench.sv
module sd_irq_status_ctl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [31:0] setPulse = '0;
  logic        cardInsert = 1'b0;
  logic        cardRemove = 1'b0;
  logic        irqOut;

  int vectors = 0;
  int misses  = 0;

  // Reference model state
  logic [31:0] mCtrl, mMask, mRaw, mStat;
  logic        mIrq;

  always #2.5 clk = ~clk;

  sd_irq_status_ctl u_sd_irq_status_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .setPulse(setPulse),
    .cardInsert(cardInsert), .cardRemove(cardRemove), .irqOut(irqOut)
  );

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return mCtrl;
      3'd1: return mMask;
      3'd2: return mRaw & mMask;
      3'd3: return mRaw;
      3'd4: return mStat;
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelReset();
    mCtrl = 32'h300; mMask = 0; mRaw = 0; mStat = 32'h100; mIrq = 1'b0;
  endtask

  task automatic modelStep(input logic w, input logic [2:0] a, input logic [31:0] d,
                           input logic [31:0] s, input logic ins, input logic rem);
    if (w) begin
      case (a)
        3'd0: mCtrl = d & 32'hFFFF_FFF8;
        3'd1: mMask = d;
        3'd2, 3'd3: mRaw = mRaw & ~d;
        3'd4: mStat = mStat & ~d;
        default: ;
      endcase
    end
    mRaw = mRaw | (s & 32'h3FFF_FFFF);
    if (rem) begin
      mRaw = (mRaw | 32'h8000_0000) & ~32'h4000_0000;
      mStat = mStat & ~32'h100;
    end else if (ins) begin
      mRaw = (mRaw | 32'h4000_0000) & ~32'h8000_0000;
      mStat = mStat | 32'h100;
    end
    mStat = mStat & 32'h100;
    mIrq = mCtrl[4] && ((mRaw & mMask) != 0);
  endtask

  task automatic compare(input string tag);
    logic [31:0] expD;
    expD = modelRead(rdAddr);
    vectors++;
    if (rdData !== expD) begin
      misses++;
      $display("FAIL %s rdData addr %0d actual %h expected %h", tag, rdAddr, rdData, expD);
    end
    vectors++;
    if (irqOut !== mIrq) begin
      misses++;
      $display("FAIL %s irqOut actual %b expected %b", tag, irqOut, mIrq);
    end
  endtask

  // One clock: drive at negedge, compare before the edge, advance the model at the edge.
  task automatic step(input string tag, input logic w, input logic [2:0] a,
                      input logic [31:0] d, input logic [31:0] s, input logic ins,
                      input logic rem, input logic [2:0] ra);
    @(negedge clk);
    wrEn = w; wrAddr = a; wrData = d; setPulse = s;
    cardInsert = ins; cardRemove = rem; rdAddr = ra;
    #1 compare(tag);
    @(posedge clk);
    modelStep(w, a, d, s, ins, rem);
  endtask

  task automatic peek(input string tag, input logic [2:0] ra);
    step(tag, 1'b0, 3'd0, 32'h0, 32'h0, 1'b0, 1'b0, ra);
  endtask

  task automatic sweep(input string tag);
    for (int k = 0; k < 8; k++) peek(tag, 3'(k));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    sweep("R1 reset");

    // R2: self-clearing control bits
    step("R2", 1'b1, 3'd0, 32'hFFFF_FFFF, 0, 0, 0, 3'd0);
    peek("R2", 3'd0);
    // R11: mask store
    step("R11", 1'b1, 3'd1, 32'h0000_000F, 0, 0, 0, 3'd1);
    peek("R11", 3'd1);
    // R6 / R3: set pulse raises raw bit and the line one cycle later
    step("R6", 1'b0, 3'd0, 0, 32'h0000_0004, 0, 0, 3'd3);
    peek("R3 irq after set", 3'd2);
    step("R6 card bits ignored", 1'b0, 3'd0, 0, 32'hC000_0000, 0, 0, 3'd3);
    peek("R6", 3'd3);
    step("R6 unmasked", 1'b0, 3'd0, 0, 32'h0001_0000, 0, 0, 3'd3);
    peek("R4 masked view", 3'd2);
    peek("R4 raw view", 3'd3);
    // R3: global enable gating
    step("R3 disable", 1'b1, 3'd0, 32'h0, 0, 0, 0, 3'd0);
    peek("R3 gated", 3'd2);
    step("R3 enable", 1'b1, 3'd0, 32'h10, 0, 0, 0, 3'd0);
    peek("R3 ungated", 3'd2);
    // R5: clear through either address
    step("R5 masked addr", 1'b1, 3'd2, 32'h0000_0004, 0, 0, 0, 3'd3);
    peek("R5", 3'd3);
    step("R5 raw addr", 1'b1, 3'd3, 32'h0001_0000, 0, 0, 0, 3'd3);
    peek("R5", 3'd3);
    // R7: card events
    step("R7 mask", 1'b1, 3'd1, 32'hC000_0000, 0, 0, 0, 3'd1);
    step("R7 insert", 1'b0, 3'd0, 0, 0, 1'b1, 1'b0, 3'd3);
    peek("R7", 3'd3);
    peek("R7", 3'd4);
    step("R7 remove", 1'b0, 3'd0, 0, 0, 1'b0, 1'b1, 3'd3);
    peek("R7", 3'd3);
    peek("R7", 3'd4);
    step("R7 insert", 1'b0, 3'd0, 0, 0, 1'b1, 1'b0, 3'd4);
    step("R7 both", 1'b0, 3'd0, 0, 0, 1'b1, 1'b1, 3'd3);
    peek("R7 both", 3'd3);
    peek("R7 both", 3'd4);
    // R8: card status clear
    step("R8 insert", 1'b0, 3'd0, 0, 0, 1'b1, 1'b0, 3'd4);
    step("R8 clear", 1'b1, 3'd4, 32'hFFFF_FFFF, 0, 0, 0, 3'd4);
    peek("R8", 3'd4);
    // R9: set beats clear in the same cycle
    step("R9 set+clr", 1'b1, 3'd3, 32'h3FFF_FFFF, 32'h0000_0101, 0, 0, 3'd3);
    peek("R9", 3'd3);
    step("R9 insert+clr", 1'b1, 3'd3, 32'hFFFF_FFFF, 0, 1'b1, 1'b0, 3'd3);
    peek("R9", 3'd3);
    step("R9 insert+state clr", 1'b1, 3'd4, 32'h100, 0, 1'b1, 1'b0, 3'd4);
    peek("R9", 3'd4);
    // R10: unmapped addresses
    for (int k = 5; k < 8; k++) begin
      step("R10 write", 1'b1, 3'(k), 32'hFFFF_FFFF, 0, 0, 0, 3'(k));
      sweep("R10");
    end
    // Mixed traffic, checked every cycle against the model (R3, R4, R5, R9)
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      step("R3 mixed", r[0] & r[1], r[4:2], $urandom, (r[5] ? $urandom : 32'h0),
           r[6] & r[7], r[8] & r[9] & r[10], r[13:11]);
    end
    sweep("R4 final");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule